// File: doc/BRIEF.md
# Completion Interrupt Coalescing Unit

This block counts, for one work queue, the finished instructions that asked to be announced by an interrupt. It decides when that pending work is worth a single coalesced interrupt. Two thresholds compete, and whichever is met first raises the line. The first is a count threshold on the number of pending completions. The second is a hold-off timer that runs while work is pending and trips after a programmed number of 1024-cycle units.

Software retires completions by writing an acknowledge amount. That amount is subtracted from the pending count rather than clearing it, and the write restarts the hold-off timer. The interrupt decision is re-evaluated straight away, so completions that land while software is busy acknowledging raise the line again instead of being lost. An enable input masks only the output line. Counting and timing carry on while it is low.

Completions arrive on a valid/ready stream input. The block never applies back-pressure: `cmpl_ready` is held high and every cycle with `cmpl_valid` high is a completion. Configuration and acknowledge traffic uses a plain single-cycle write port.

Top module: `done_coalescer`

## Requirements
- R1: A cycle with `cmpl_valid` high and `cmpl_flag` high raises the pending count by exactly one. A completion with `cmpl_flag` low, or a cycle without `cmpl_valid`, leaves the count unchanged. The count is visible on `done_count_o` one cycle later.
- R2: A write with `reg_wr_sel` = 0 (acknowledge) subtracts `reg_wr_data[19:0]` from the count. If the amount exceeds the count, the count becomes zero.
- R3: When a flagged completion and an acknowledge fall in the same cycle, both are applied: the count becomes count + 1 - amount, clamped at zero.
- R4: While the count is zero, the hold-off timer is held at zero, and `intr_o` is low in the following cycle.
- R5: With `intr_en` high and a nonzero count at or above the count threshold, `intr_o` is high in the next cycle. `intr_o` is a registered level.
- R6: A count threshold of zero behaves exactly as a threshold of one.
- R7: The time trigger is met when the timer is at least time_wait × 1024. The timer counts once per cycle while the count is nonzero and saturates at its maximum. A time_wait of zero disables the time trigger.
- R8: An acknowledge write or a count load write restarts the timer from zero. The interrupt is then recomputed from the new count, so a remaining count that still meets the threshold raises `intr_o` again without delay.
- R9: While `intr_en` is low, `intr_o` is low in the next cycle, but the count and the timer keep evolving as normal.
- R10: A write with `reg_wr_sel` = 1 loads `reg_wr_data[19:0]` into the count. A flagged completion in the same cycle adds one on top of the loaded value.
- R11: A write with `reg_wr_sel` = 2 sets the count threshold from `reg_wr_data[19:0]` and time_wait from `reg_wr_data[35:20]`. A write with `reg_wr_sel` = 3 changes nothing.
- R12: An increment at the count's maximum value (all ones) leaves it at the maximum. `cmpl_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_valid | input | 1 | A completion is presented this cycle |
| cmpl_flag | input | 1 | The completion requests a done interrupt |
| cmpl_ready | output | 1 | Always high; completions are never stalled |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 acknowledge, 1 count load, 2 thresholds, 3 none |
| reg_wr_data | input | 36 | Write data (see R2, R10, R11) |
| intr_en | input | 1 | Interrupt output enable |
| intr_o | output | 1 | Coalesced completion interrupt level |
| done_count_o | output | 20 | Current pending count (acknowledge readback) |

## Verification
Three functions can fall in the same cycle: a flagged completion, an acknowledge or count load, and the threshold evaluation that follows. Directed steps drive a completion together with an acknowledge, and together with a load. They also acknowledge down to a remainder that still meets the threshold, to provoke the race in which the line must come straight back. A long random phase then mixes all three at high density. Every cycle is judged against a bench model built from the requirements, which compares the count, the interrupt level and the ready signal.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // register write selector encoding (R2, R10, R11)
  typedef enum logic [1:0] {
    SEL_ACK  = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/coal_counter.sv
module coal_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ack_en,
  input  logic [CNT_W-1:0] ack_amt,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] sat;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    base = load_en ? load_val : count_q;
    sum  = {1'b0, base} + {{CNT_W{1'b0}}, inc};
    sat  = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    if (ack_en) nxt = (sat >= ack_amt) ? (sat - ack_amt) : '0;
    else        nxt = sat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= nxt;
  end
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int TMR_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  output logic [TMR_W-1:0] tmr_q
);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                 tmr_q <= '0;
    else if (!active || restart) tmr_q <= '0;
    else if (tmr_q != TMR_MAX)  tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/coal_cfg.sv
module coal_cfg #(
  parameter int CNT_W = 20,
  parameter int TW_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CNT_W+TW_W-1:0] wr_data,
  output logic [CNT_W-1:0]      num_wait_q,
  output logic [TW_W-1:0]       time_wait_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_wait_q  <= '0;
      time_wait_q <= '0;
    end else if (wr_en) begin
      num_wait_q  <= wr_data[CNT_W-1:0];
      time_wait_q <= wr_data[CNT_W+TW_W-1:CNT_W];
    end
  end
endmodule

// File: rtl/coal_decide.sv
module coal_decide #(
  parameter int CNT_W      = 20,
  parameter int TW_W       = 16,
  parameter int SCALE_LOG2 = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [CNT_W-1:0]           count,
  input  logic [TW_W+SCALE_LOG2-1:0] tmr,
  input  logic [CNT_W-1:0]           num_wait,
  input  logic [TW_W-1:0]            time_wait,
  output logic                       intr_q
);
  localparam int TMR_W = TW_W + SCALE_LOG2;

  logic [CNT_W-1:0] eff_nw;
  logic [TMR_W-1:0] tmr_lim;
  logic             time_hit, cnt_hit, fire;

  always_comb begin
    eff_nw   = (num_wait == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : num_wait;
    tmr_lim  = {time_wait, {SCALE_LOG2{1'b0}}};
    time_hit = (time_wait != '0) && (tmr >= tmr_lim);
    cnt_hit  = (count >= eff_nw);
    fire     = en && (count != '0) && (time_hit || cnt_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) intr_q <= 1'b0;
    else        intr_q <= fire;
  end
endmodule

// File: rtl/done_coalescer.sv
module done_coalescer #(
  parameter int CNT_W      = 20,
  parameter int TW_W       = 16,
  parameter int SCALE_LOG2 = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmpl_valid,
  input  logic                  cmpl_flag,
  output logic                  cmpl_ready,
  input  logic                  reg_wr_en,
  input  logic [1:0]            reg_wr_sel,
  input  logic [CNT_W+TW_W-1:0] reg_wr_data,
  input  logic                  intr_en,
  output logic                  intr_o,
  output logic [CNT_W-1:0]      done_count_o
);
  import coal_pkg::*;
  localparam int TMR_W = TW_W + SCALE_LOG2;

  wr_sel_e          sel;
  logic             do_ack, do_load, do_cfg, do_inc;
  logic [CNT_W-1:0] count_q, cfg_num_wait;
  logic [TW_W-1:0]  cfg_time_wait;
  logic [TMR_W-1:0] tmr_value;

  always_comb begin
    sel     = wr_sel_e'(reg_wr_sel);
    do_ack  = reg_wr_en && (sel == SEL_ACK);
    do_load = reg_wr_en && (sel == SEL_LOAD);
    do_cfg  = reg_wr_en && (sel == SEL_CFG);
    do_inc  = cmpl_valid && cmpl_flag;
  end

  assign cmpl_ready   = 1'b1;
  assign done_count_o = count_q;

  coal_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(do_inc),
    .ack_en(do_ack), .ack_amt(reg_wr_data[CNT_W-1:0]),
    .load_en(do_load), .load_val(reg_wr_data[CNT_W-1:0]),
    .count_q(count_q)
  );

  coal_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .active(count_q != '0),
    .restart(do_ack || do_load), .tmr_q(tmr_value)
  );

  coal_cfg #(.CNT_W(CNT_W), .TW_W(TW_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(do_cfg), .wr_data(reg_wr_data),
    .num_wait_q(cfg_num_wait), .time_wait_q(cfg_time_wait)
  );

  coal_decide #(.CNT_W(CNT_W), .TW_W(TW_W), .SCALE_LOG2(SCALE_LOG2)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(intr_en), .count(count_q),
    .tmr(tmr_value), .num_wait(cfg_num_wait), .time_wait(cfg_time_wait),
    .intr_q(intr_o)
  );
endmodule

// File: rtl/done_coalescer_chk.sv
module done_coalescer_chk #(
  parameter int CNT_W      = 20,
  parameter int TW_W       = 16,
  parameter int SCALE_LOG2 = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmpl_valid,
  input logic                       cmpl_flag,
  input logic                       reg_wr_en,
  input logic [1:0]                 reg_wr_sel,
  input logic [CNT_W+TW_W-1:0]      reg_wr_data,
  input logic                       intr_en,
  input logic                       intr_o,
  input logic [CNT_W-1:0]           done_count_o,
  input logic [CNT_W-1:0]           nw_q,
  input logic [TW_W-1:0]            tw_q,
  input logic [TW_W+SCALE_LOG2-1:0] tmr_q
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] eff;
  logic             inc, ack, ld;
  assign eff = (nw_q == '0) ? CNT_W'(1) : nw_q;
  assign inc = cmpl_valid && cmpl_flag;
  assign ack = reg_wr_en && (reg_wr_sel == 2'd0);
  assign ld  = reg_wr_en && (reg_wr_sel == 2'd1);

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !reg_wr_en && done_count_o != CMAX |=> done_count_o == $past(done_count_o) + CNT_W'(1));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !ack && !ld |=> $stable(done_count_o));
  p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !inc && reg_wr_data[CNT_W-1:0] >= done_count_o |=> done_count_o == '0);
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_count_o == '0 |=> !intr_o);
  p_cnt_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    intr_en && done_count_o != '0 && done_count_o >= eff |=> intr_o);
  p_time_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tw_q == '0 && done_count_o < eff |=> !intr_o);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack || ld |=> tmr_q == '0);
  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_en |=> !intr_o);
endmodule

bind done_coalescer done_coalescer_chk #(.CNT_W(CNT_W), .TW_W(TW_W), .SCALE_LOG2(SCALE_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_flag(cmpl_flag),
  .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
  .intr_en(intr_en), .intr_o(intr_o), .done_count_o(done_count_o),
  .nw_q(cfg_num_wait), .tw_q(cfg_time_wait), .tmr_q(tmr_value)
);

// File: tb/sim_done_coalescer.sv
module sim_done_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 20;
  localparam int TW = 16;
  localparam longint CMAX = 64'd1048575;
  localparam longint TMAX = 64'd67108863;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmpl_valid = 0, cmpl_flag = 0, reg_wr_en = 0, intr_en = 0;
  logic [1:0] reg_wr_sel = 0;
  logic [CW+TW-1:0] reg_wr_data = '0;
  logic cmpl_ready, intr_o;
  logic [CW-1:0] done_count_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  string req = "R4";

  longint m_cnt = 0, m_nw = 0, m_tw = 0, m_tmr = 0;
  bit m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  done_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_flag(cmpl_flag),
    .cmpl_ready(cmpl_ready), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .intr_en(intr_en), .intr_o(intr_o),
    .done_count_o(done_count_o)
  );

  function automatic bit cond_now();
    longint eff = (m_nw == 0) ? 1 : m_nw;
    return (m_cnt != 0) && ((m_tw != 0 && m_tmr >= m_tw * 1024) || m_cnt >= eff);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model follows requirements, then outputs are compared
  task automatic step();
    longint b, nc, nt;
    bit ni, rs;
    @(posedge clk);
    if (!rst_n) begin
      m_cnt = 0; m_nw = 0; m_tw = 0; m_tmr = 0; m_irq = 0;
    end else begin
      ni = cond_now() && intr_en;                                   // R5 R7 R9
      rs = reg_wr_en && (reg_wr_sel == 2'd0 || reg_wr_sel == 2'd1); // R8
      b = (reg_wr_en && reg_wr_sel == 2'd1) ? longint'(reg_wr_data[CW-1:0]) : m_cnt; // R10
      if (cmpl_valid && cmpl_flag) b = (b + 1 > CMAX) ? CMAX : b + 1; // R1 R12
      if (reg_wr_en && reg_wr_sel == 2'd0) begin                    // R2 R3
        b = b - longint'(reg_wr_data[CW-1:0]);
        if (b < 0) b = 0;
      end
      nc = b;
      if (m_cnt == 0 || rs) nt = 0;                                 // R4
      else nt = (m_tmr == TMAX) ? TMAX : m_tmr + 1;
      if (reg_wr_en && reg_wr_sel == 2'd2) begin                    // R11
        m_nw = longint'(reg_wr_data[CW-1:0]);
        m_tw = longint'(reg_wr_data[CW+TW-1:CW]);
      end
      m_cnt = nc; m_tmr = nt; m_irq = ni;
    end
    @(negedge clk);
    check({req, " count"}, longint'(done_count_o), m_cnt);
    check({req, " intr"}, longint'(intr_o), longint'(m_irq));
    check("R12 ready", longint'(cmpl_ready), 1);
  endtask

  task automatic idle(); cmpl_valid = 0; cmpl_flag = 0; reg_wr_en = 0; endtask
  task automatic wr(input logic [1:0] s, input logic [CW+TW-1:0] d);
    reg_wr_en = 1; reg_wr_sel = s; reg_wr_data = d;
  endtask
  task automatic cfg(input int nw, input int tw);
    idle(); wr(2'd2, {TW'(tw), CW'(nw)}); step(); idle();
  endtask
  task automatic comp(input bit f); cmpl_valid = 1; cmpl_flag = f; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    intr_en = 1;
    repeat (3) step();
    rst_n = 1;
    req = "R4"; step(); step();
    check("R4 reset count", longint'(done_count_o), 0);

    req = "R5"; cfg(4, 0); intr_en = 1;
    for (int i = 0; i < 4; i++) begin comp(1); step(); end
    idle(); step(); step();
    check("R5 intr at threshold", longint'(intr_o), 1);

    req = "R1";
    for (int i = 0; i < 5; i++) begin comp(0); step(); end
    idle(); step();
    check("R1 unflagged no change", longint'(done_count_o), 4);

    req = "R2"; wr(2'd0, 36'd2); step(); idle(); step();
    check("R2 ack subtract", longint'(done_count_o), 2);
    req = "R3"; comp(1); wr(2'd0, 36'd1); step(); idle(); step();
    check("R3 same cycle", longint'(done_count_o), 2);
    req = "R2"; wr(2'd0, 36'd100); step(); idle(); step();
    check("R2 clamp", longint'(done_count_o), 0);

    req = "R6"; cfg(0, 0); comp(1); step(); idle(); step();
    check("R6 zero threshold acts as one", longint'(intr_o), 1);

    req = "R8"; cfg(3, 0);
    for (int i = 0; i < 5; i++) begin comp(1); step(); end
    idle(); wr(2'd0, 36'd3); step(); idle(); step();
    check("R8 reraise after ack", longint'(intr_o), 1);

    req = "R10"; comp(1); wr(2'd1, 36'd7); step(); idle(); step();
    check("R10 load plus inc", longint'(done_count_o), 8);

    req = "R9"; intr_en = 0; step(); step();
    check("R9 masked", longint'(intr_o), 0);
    comp(1); step(); idle(); step();
    check("R9 counting continues", longint'(done_count_o), 9);
    intr_en = 1;

    req = "R11"; wr(2'd3, 36'hF_FFFF_FFFF); step(); idle(); step();
    check("R11 sel3 no effect", longint'(done_count_o), 9);

    req = "R7"; cfg(1000, 1); wr(2'd1, 36'd1); step(); idle();
    for (int i = 0; i < 1020; i++) step();
    check("R7 before time limit", longint'(intr_o), 0);
    for (int i = 0; i < 10; i++) step();
    check("R7 time trigger", longint'(intr_o), 1);
    cfg(1000, 0); wr(2'd0, 36'd0); step(); idle();
    for (int i = 0; i < 1100; i++) step();
    check("R7 time disabled", longint'(intr_o), 0);

    req = "R12"; wr(2'd1, 36'hF_FFFF); step(); comp(1); idle(); comp(1); step(); idle(); step();
    check("R12 saturate", longint'(done_count_o), CMAX);

    req = "R3 random";
    void'($urandom(32'd1234));
    cfg(6, 1); wr(2'd1, 36'd0); step(); idle();
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom % 100);
      cmpl_valid = ($urandom % 3) != 0;
      cmpl_flag  = ($urandom % 4) != 0;
      reg_wr_en  = (r < 12);
      reg_wr_sel = (r < 6) ? 2'd0 : (r < 8) ? 2'd1 : (r < 10) ? 2'd2 : 2'd3;
      reg_wr_data = {TW'($urandom % 3), CW'($urandom % 9)};
      intr_en = ($urandom % 10) != 0;
      step();
    end
    idle(); step();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule